// File: doc/BRIEF.md
# Parallel MCU-Style LCD Panel Writer

This block feeds a parallel LCD module that has its own controller and frame memory. It accepts a stream of 24-bit RGB pixels and command words over a valid/ready handshake. Each pixel is reduced to one of four colour depths, cut into bus-wide beats and written to the panel with strobe timing. That timing is derived from a panel time unit equal to `DIV` system clocks (32 by default). Two panel protocols are supported. The first has separate active-low write and read strobes. The second has a read/write direction line and an active-high enable pulse.

Two panels share the data bus and the register-select line, and each panel has its own chip select. When a host processor wants to drive the panels itself, for example while the pixel path is powered down, a bypass input connects the host's chip selects, register select, strobes and data straight to the panel pins. Internal transfers are blocked while bypass is active.

The colour format, bus width, protocol and panel select are sampled when a word is accepted. Bypass is changed only while the block is idle.

Top module: `lcd_mcu_if`

## Requirements
- R1: After reset both chip selects are high, the write pin and (in strobe protocol) the read pin are high, the data bus is zero and not driven, register select is low, `busy` is low and `in_ready` is high.
- R2: Pixel reduction takes the most significant bits of each channel. Format code 0 gives {R[7:5],G[7:5],B[7:6]} (8 bits). Code 1 gives {R[7:4],G[7:4],B[7:4]} (12 bits). Code 2 gives {R[7:3],G[7:2],B[7:3]} (16 bits). Code 3 gives {R[7:2],G[7:2],B[7:2]} (18 bits).
- R3: Bus code 0 selects 8 bits, code 1 selects 16 bits, and codes 2 and 3 select 18 bits. A pixel of width W on a bus of width B is sent as ceil(W/B) beats of its value zero-extended to beats×B bits, most significant beat first, in `lcd_dout[B-1:0]`, with the lanes above B at zero.
- R4: Register select is low for a command (`in_cmd`=1) and high for a pixel, and it does not change during a transfer. A command is a single beat carrying `in_data[B-1:0]`.
- R5: Strobe protocol (`cfg_m68`=0). Chip select and register select become valid 2×(DIV/2) cycles before the first write strobe. `lcd_wr_n` goes low for DIV/2 cycles per beat. Data is held DIV/2 cycles after each strobe. Between beats the strobe is high for DIV cycles. Chip select rises DIV/2 cycles after the last strobe ends, and `lcd_rd_n` stays high.
- R6: Enable protocol (`cfg_m68`=1). `lcd_wr_n` serves as the direction line and is low for the whole transfer. `lcd_rd_n` serves as the enable, which is low at idle and high for DIV/2 cycles per beat, with the same spacing as R5.
- R7: `cfg_panel`=0 drives `lcd_cs_n[0]` low and `cfg_panel`=1 drives `lcd_cs_n[1]` low. At most one chip select is low at a time, and it stays low across all beats of a word.
- R8: `in_ready` is high only when the block is idle and not in bypass. `busy` is high from the accepting edge until chip select rises. A valid word offered while `in_ready` is low is ignored.
- R9: With `cfg_bypass`=1 the panel chip selects, register select, write pin, read pin and data equal the host inputs. `hb_rdata` equals `lcd_din` (zero outside bypass). `lcd_doe` is high when a host chip select is low and either (strobe protocol) `hb_rd_n` is high or (enable protocol) `hb_wr_n` is low. No internal transfer is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_m68 | input | 1 | 0 strobe protocol, 1 direction plus enable protocol |
| cfg_fmt | input | 2 | Colour format code |
| cfg_bus | input | 2 | Bus width code |
| cfg_panel | input | 1 | Panel chosen for internal transfers |
| cfg_bypass | input | 1 | Host drives the panel directly |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be accepted |
| in_cmd | input | 1 | 1 command word, 0 pixel |
| in_data | input | 24 | Pixel {R,G,B} or command in low bits |
| busy | output | 1 | Transfer in progress |
| hb_cs_n | input | 2 | Host chip selects |
| hb_rs | input | 1 | Host register select |
| hb_wr_n | input | 1 | Host write strobe or direction |
| hb_rd_n | input | 1 | Host read strobe or enable |
| hb_wdata | input | 18 | Host write data |
| hb_rdata | output | 18 | Panel data returned to host |
| lcd_cs_n | output | 2 | Panel chip selects |
| lcd_rs | output | 1 | Panel register select |
| lcd_wr_n | output | 1 | Write strobe or direction |
| lcd_rd_n | output | 1 | Read strobe or enable |
| lcd_dout | output | 18 | Panel data out |
| lcd_doe | output | 1 | Panel data output enable |
| lcd_din | input | 18 | Panel data in |

## Verification
The assertions check the bus timing on every cycle. They cover the minimum strobe width, chip-select and register-select setup before each strobe, data hold at the strobe's trailing edge, and the stability of register select and data while a strobe is active. They also check that only one chip select is low, that the direction line is low while the enable is high, and the rule that acceptance happens only when idle.

The colour reductions, the order and content of the beats, the exact cycle counts of each phase, panel selection, dropped words and the bypass connections depend on the chosen configuration and data. Only the bench scenarios can show those.

// File: rtl/lcd_mcu_if.sv
module lcd_mcu_if #(
  parameter int DIV = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_m68,
  input  logic [1:0]  cfg_fmt,
  input  logic [1:0]  cfg_bus,
  input  logic        cfg_panel,
  input  logic        cfg_bypass,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        in_cmd,
  input  logic [23:0] in_data,
  output logic        busy,
  input  logic [1:0]  hb_cs_n,
  input  logic        hb_rs,
  input  logic        hb_wr_n,
  input  logic        hb_rd_n,
  input  logic [17:0] hb_wdata,
  output logic [17:0] hb_rdata,
  output logic [1:0]  lcd_cs_n,
  output logic        lcd_rs,
  output logic        lcd_wr_n,
  output logic        lcd_rd_n,
  output logic [17:0] lcd_dout,
  output logic        lcd_doe,
  input  logic [17:0] lcd_din
);
  localparam int H  = DIV / 2;
  localparam int CW = $clog2(DIV + 1);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic [1:0]  left;
  logic [4:0]  bw;
  logic [17:0] pv;
  logic        rs_q, pan_q, m68_q;

  logic [17:0] pix;
  logic [4:0]  pw, bwi;
  logic [1:0]  nbm1;

  always_comb begin
    case (cfg_fmt)
      2'd0: begin pix = {10'd0, in_data[23:21], in_data[15:13], in_data[7:6]}; pw = 5'd8;  end
      2'd1: begin pix = {6'd0,  in_data[23:20], in_data[15:12], in_data[7:4]}; pw = 5'd12; end
      2'd2: begin pix = {2'd0,  in_data[23:19], in_data[15:10], in_data[7:3]}; pw = 5'd16; end
      default: begin pix = {in_data[23:18], in_data[15:10], in_data[7:2]};     pw = 5'd18; end
    endcase
    case (cfg_bus)
      2'd0:    bwi = 5'd8;
      2'd1:    bwi = 5'd16;
      default: bwi = 5'd18;
    endcase
    if (in_cmd || pw <= bwi)                nbm1 = 2'd0;
    else if ({1'b0, pw} <= {bwi, 1'b0})     nbm1 = 2'd1;
    else                                    nbm1 = 2'd2;
  end

  wire act    = (st != S_IDLE);
  wire stb    = (st == S_STRB);
  wire accept = in_valid && in_ready;

  assign in_ready = !act && !cfg_bypass;
  assign busy     = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      left  <= '0;
      bw    <= 5'd18;
      pv    <= '0;
      rs_q  <= 1'b0;
      pan_q <= 1'b0;
      m68_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          st    <= S_SETUP;
          cnt   <= CW'(2 * H - 1);
          left  <= nbm1;
          bw    <= bwi;
          pv    <= in_cmd ? in_data[17:0] : pix;
          rs_q  <= !in_cmd;
          pan_q <= cfg_panel;
          m68_q <= cfg_m68;
        end
        S_SETUP: if (cnt == '0) begin st <= S_STRB; cnt <= CW'(H - 1); end
                 else cnt <= cnt - 1'b1;
        S_STRB:  if (cnt == '0) begin st <= S_HOLD; cnt <= CW'(H - 1); end
                 else cnt <= cnt - 1'b1;
        default: if (cnt == '0) begin
                   if (left != 2'd0) begin
                     left <= left - 1'b1;
                     st   <= S_SETUP;
                     cnt  <= CW'(H - 1);
                   end else st <= S_IDLE;
                 end else cnt <= cnt - 1'b1;
      endcase
    end
  end

  logic [4:0]  sh;
  logic [17:0] mask, chunk;
  always_comb begin
    case (left)
      2'd2:    sh = {bw[3:0], 1'b0};
      2'd1:    sh = bw;
      default: sh = 5'd0;
    endcase
    mask  = ~(18'h3FFFF << bw);
    chunk = (pv >> sh) & mask;
  end

  wire       mode   = act ? m68_q : cfg_m68;
  wire [1:0] i_cs_n = act ? (pan_q ? 2'b01 : 2'b10) : 2'b11;
  wire       i_wr_n = mode ? !act : !stb;
  wire       i_rd_n = mode ? stb : 1'b1;
  wire       b_oe   = !(&hb_cs_n) && (cfg_m68 ? !hb_wr_n : hb_rd_n);

  assign lcd_cs_n = cfg_bypass ? hb_cs_n  : i_cs_n;
  assign lcd_rs   = cfg_bypass ? hb_rs    : rs_q;
  assign lcd_wr_n = cfg_bypass ? hb_wr_n  : i_wr_n;
  assign lcd_rd_n = cfg_bypass ? hb_rd_n  : i_rd_n;
  assign lcd_dout = cfg_bypass ? hb_wdata : (act ? chunk : 18'd0);
  assign lcd_doe  = cfg_bypass ? b_oe     : act;
  assign hb_rdata = cfg_bypass ? lcd_din  : 18'd0;

endmodule

// File: rtl/lcd_mcu_if_chk.sv
module lcd_mcu_if_chk #(
  parameter int DIV = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_m68,
  input logic        cfg_bypass,
  input logic        in_valid,
  input logic        in_ready,
  input logic        busy,
  input logic [1:0]  lcd_cs_n,
  input logic        lcd_rs,
  input logic        lcd_wr_n,
  input logic        lcd_rd_n,
  input logic [17:0] lcd_dout
);
  localparam int H  = DIV / 2;
  localparam int KW = $clog2(2 * DIV + 2) + 1;

  wire str = !cfg_bypass && (cfg_m68 ? lcd_rd_n : !lcd_wr_n);

  logic          str_q, rs_q;
  logic [17:0]   dout_q;
  logic [KW-1:0] str_cnt, cs_cnt, rs_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q   <= 1'b0;
      rs_q    <= 1'b0;
      dout_q  <= '0;
      str_cnt <= '0;
      cs_cnt  <= '0;
      rs_cnt  <= '0;
    end else begin
      str_q  <= str;
      rs_q   <= lcd_rs;
      dout_q <= lcd_dout;
      str_cnt <= !str ? '0 : (&str_cnt ? str_cnt : str_cnt + 1'b1);
      cs_cnt  <= (&lcd_cs_n) ? '0 : (&cs_cnt ? cs_cnt : cs_cnt + 1'b1);
      rs_cnt  <= (lcd_rs != rs_q) ? KW'(1) : (&rs_cnt ? rs_cnt : rs_cnt + 1'b1);
    end
  end

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!busy && !cfg_bypass));
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy);
  p_one_cs_r7: assert property (@(posedge clk) disable iff (!rst_n || cfg_bypass)
    $onehot0(~lcd_cs_n));
  p_strobe_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
    str |-> (lcd_cs_n != 2'b11));
  p_strobe_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (str_q && !str) |-> (str_cnt >= KW'(H)));
  p_cs_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (str && !str_q) |-> (cs_cnt >= KW'(H)));
  p_rs_setup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (str && !str_q) |-> (rs_cnt >= KW'(2 * H)));
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || cfg_bypass)
    (str_q && !str) |-> (lcd_dout == dout_q));
  p_stable_in_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (str && str_q) |-> (lcd_rs == rs_q && lcd_dout == dout_q));
  p_dir_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_m68 && str) |-> !lcd_wr_n);

endmodule

bind lcd_mcu_if lcd_mcu_if_chk #(.DIV(DIV)) u_chk (.*);

// File: tb/sim_lcd_mcu_if.sv
module sim_lcd_mcu_if;
  localparam int DIV = 32;
  localparam int H   = DIV / 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_m68, cfg_panel, cfg_bypass;
  logic [1:0] cfg_fmt, cfg_bus;
  logic in_valid, in_cmd;
  logic [23:0] in_data;
  logic in_ready, busy;
  logic [1:0] hb_cs_n;
  logic hb_rs, hb_wr_n, hb_rd_n;
  logic [17:0] hb_wdata, hb_rdata;
  logic [1:0] lcd_cs_n;
  logic lcd_rs, lcd_wr_n, lcd_rd_n, lcd_doe;
  logic [17:0] lcd_dout, lcd_din;

  int checks = 0;
  int errors = 0;

  int nb, pre, post, gap;
  int bdat [4];
  int bwid [4];
  logic cs_seen, rs_seen;
  logic [1:0] cs_val;
  logic chg_bad, rw_bad;

  always #5 clk = ~clk;

  lcd_mcu_if #(.DIV(DIV)) u0 (.*);

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int pix_of(input int f, input logic [23:0] d);
    logic [7:0] r, g, b;
    r = d[23:16]; g = d[15:8]; b = d[7:0];
    case (f)
      0: return int'({r[7:5], g[7:5], b[7:6]});
      1: return int'({r[7:4], g[7:4], b[7:4]});
      2: return int'({r[7:3], g[7:2], b[7:3]});
      default: return int'({r[7:2], g[7:2], b[7:2]});
    endcase
  endfunction

  function automatic int busw(input int bcode);
    return (bcode == 0) ? 8 : (bcode == 1) ? 16 : 18;
  endfunction

  function automatic int fmtw(input int f);
    return (f == 0) ? 8 : (f == 1) ? 12 : (f == 2) ? 16 : 18;
  endfunction

  function automatic int exp_n(input logic cmd, input int f, input int bcode);
    int b = busw(bcode);
    return cmd ? 1 : (fmtw(f) + b - 1) / b;
  endfunction

  function automatic int exp_beat(input logic cmd, input int f, input int bcode,
                                  input logic [23:0] d, input int k);
    int b = busw(bcode);
    int n = exp_n(cmd, f, bcode);
    int m = (1 << b) - 1;
    int v = cmd ? (int'(d[17:0]) & m) : pix_of(f, d);
    return (v >> ((n - 1 - k) * b)) & m;
  endfunction

  function automatic logic strobe_on();
    return cfg_m68 ? lcd_rd_n : !lcd_wr_n;
  endfunction

  task automatic xfer(input logic cmd, input logic [23:0] d);
    logic prev;
    int run, guard;
    logic [17:0] dl;
    @(negedge clk);
    in_valid = 1'b1; in_cmd = cmd; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    nb = 0; pre = 0; post = 0; gap = -1; run = 0; prev = 1'b0; guard = 0; dl = '0;
    cs_val = lcd_cs_n; rs_seen = lcd_rs; chg_bad = 1'b0; rw_bad = 1'b0;
    cs_seen = (lcd_cs_n != 2'b11);
    while (lcd_cs_n != 2'b11 && guard < 2000) begin
      if (lcd_cs_n != cs_val || lcd_rs != rs_seen) chg_bad = 1'b1;
      if (cfg_m68 && lcd_wr_n) rw_bad = 1'b1;
      if (strobe_on()) begin
        if (!prev) begin
          if (nb > 0 && gap < 0) gap = post;
          run = 0;
        end
        run++;
        dl = lcd_dout;
        post = 0;
      end else begin
        if (prev) begin
          if (nb < 4) begin bdat[nb] = int'(dl); bwid[nb] = run; end
          nb++;
        end
        if (nb == 0) pre++; else post++;
      end
      prev = strobe_on();
      guard++;
      @(negedge clk);
    end
  endtask

  task automatic run_and_check(input string tag, input logic cmd,
                               input logic [23:0] d, input int pan);
    int n;
    check({tag, " R8 ready before"}, int'(in_ready), 1);
    xfer(cmd, d);
    n = exp_n(cmd, int'(cfg_fmt), int'(cfg_bus));
    check({tag, " R7 cs active"}, int'(cs_seen), 1);
    check({tag, " R7 panel cs"}, int'(cs_val), (pan == 1) ? 1 : 2);
    check({tag, " R7 R4 cs/rs steady"}, int'(chg_bad), 0);
    check({tag, " R4 rs level"}, int'(rs_seen), cmd ? 0 : 1);
    check({tag, " R3 beats"}, nb, n);
    for (int k = 0; k < n && k < 4; k++) begin
      check({tag, " R2 R3 beat data"}, bdat[k],
            exp_beat(cmd, int'(cfg_fmt), int'(cfg_bus), d, k));
      check({tag, " R5 strobe width"}, bwid[k], H);
    end
    check({tag, " R5 setup"}, pre, 2 * H);
    check({tag, " R5 hold"}, post, H);
    if (n > 1) check({tag, " R5 beat gap"}, gap, 2 * H);
    if (cfg_m68) begin
      check({tag, " R6 dir low"}, int'(rw_bad), 0);
      check({tag, " R6 enable idle"}, int'(lcd_rd_n), 0);
    end else begin
      check({tag, " R5 rd idle"}, int'(lcd_rd_n), 1);
    end
    check({tag, " R8 busy clear"}, int'(busy), 0);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(in_ready), 1);
    check("R1 cs", int'(lcd_cs_n), 3);
    check("R1 wr", int'(lcd_wr_n), 1);
    check("R1 rd", int'(lcd_rd_n), 1);
    check("R1 doe", int'(lcd_doe), 0);
    check("R1 dout", int'(lcd_dout), 0);
    check("R1 rs", int'(lcd_rs), 0);
  endtask

  task automatic t_formats();
    cfg_bus = 2'd2; cfg_panel = 1'b0;
    for (int f = 0; f < 4; f++) begin
      cfg_fmt = 2'(f);
      run_and_check("fmt18", 1'b0, 24'hC3A56F, 0);
    end
  endtask

  task automatic t_beats();
    cfg_bus = 2'd0;
    cfg_fmt = 2'd1; run_and_check("444on8",  1'b0, 24'hF1E2D3, 0);
    cfg_fmt = 2'd2; run_and_check("565on8",  1'b0, 24'h5AA5C7, 0);
    cfg_fmt = 2'd3; run_and_check("666on8",  1'b0, 24'hFC80FC, 0);
    cfg_bus = 2'd1;
    cfg_fmt = 2'd3; run_and_check("666on16", 1'b0, 24'h9C3F68, 0);
    cfg_fmt = 2'd2; run_and_check("565on16", 1'b0, 24'h12EF77, 0);
    cfg_bus = 2'd3;
    cfg_fmt = 2'd3; run_and_check("666bus3", 1'b0, 24'h3070B0, 0);
  endtask

  task automatic t_cmd();
    cfg_bus = 2'd0; cfg_fmt = 2'd3;
    run_and_check("cmd8", 1'b1, 24'hABCDEF, 0);
    cfg_bus = 2'd2;
    run_and_check("cmd18", 1'b1, 24'hABCDEF, 0);
  endtask

  task automatic t_m68();
    cfg_m68 = 1'b1;
    @(negedge clk);
    check("R6 enable low at idle", int'(lcd_rd_n), 0);
    check("R6 dir high at idle", int'(lcd_wr_n), 1);
    cfg_bus = 2'd0; cfg_fmt = 2'd2;
    run_and_check("m68 565on8", 1'b0, 24'h8844CC, 0);
    cfg_bus = 2'd2;
    run_and_check("m68 cmd", 1'b1, 24'h00002C, 0);
    cfg_m68 = 1'b0;
  endtask

  task automatic t_panel();
    cfg_panel = 1'b1; cfg_bus = 2'd0; cfg_fmt = 2'd1;
    run_and_check("panel1", 1'b0, 24'h102030, 1);
    cfg_panel = 1'b0;
  endtask

  task automatic t_handshake();
    cfg_bus = 2'd2; cfg_fmt = 2'd0;
    @(negedge clk);
    in_valid = 1'b1; in_cmd = 1'b0; in_data = 24'hFFFFFF;
    @(negedge clk);
    check("R8 busy after accept", int'(busy), 1);
    check("R8 ready low while busy", int'(in_ready), 0);
    in_data = 24'h000000;
    repeat (10) @(negedge clk);
    in_valid = 1'b0;
    while (busy) @(negedge clk);
    repeat (5) @(negedge clk);
    check("R8 offered word dropped", int'(lcd_cs_n), 3);
    check("R8 still idle", int'(busy), 0);
    check("R8 ready again", int'(in_ready), 1);
  endtask

  task automatic t_bypass();
    cfg_bypass = 1'b1;
    hb_cs_n = 2'b10; hb_rs = 1'b1; hb_wr_n = 1'b0; hb_rd_n = 1'b1;
    hb_wdata = 18'h2A5C3; lcd_din = 18'h1F0F0;
    @(negedge clk);
    check("R9 R8 ready low", int'(in_ready), 0);
    check("R9 cs pass", int'(lcd_cs_n), 2);
    check("R9 rs pass", int'(lcd_rs), 1);
    check("R9 wr pass", int'(lcd_wr_n), 0);
    check("R9 rd pass", int'(lcd_rd_n), 1);
    check("R9 data pass", int'(lcd_dout), 'h2A5C3);
    check("R9 readback", int'(hb_rdata), 'h1F0F0);
    check("R9 doe write", int'(lcd_doe), 1);
    hb_rd_n = 1'b0; hb_wr_n = 1'b1; hb_cs_n = 2'b01;
    @(negedge clk);
    check("R9 doe read", int'(lcd_doe), 0);
    check("R9 cs1 pass", int'(lcd_cs_n), 1);
    hb_cs_n = 2'b11; hb_rd_n = 1'b1;
    in_valid = 1'b1; in_cmd = 1'b0; in_data = 24'h123456;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    check("R9 no transfer", int'(busy), 0);
    cfg_bypass = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 nothing started", int'(lcd_cs_n), 3);
    check("R9 idle after", int'(busy), 0);
    check("R9 readback off", int'(hb_rdata), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    cfg_m68 = 1'b0; cfg_panel = 1'b0; cfg_bypass = 1'b0;
    cfg_fmt = 2'd3; cfg_bus = 2'd2;
    in_valid = 1'b0; in_cmd = 1'b0; in_data = '0;
    hb_cs_n = 2'b11; hb_rs = 1'b0; hb_wr_n = 1'b1; hb_rd_n = 1'b1;
    hb_wdata = '0; lcd_din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_formats();
    t_beats();
    t_cmd();
    t_m68();
    t_panel();
    t_handshake();
    t_bypass();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule